// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers interrupt requests from 41 fixed sources and decides which one the CPU should take next. Each source has a 5-bit priority level that can be changed through a write port. Level 0 switches the source off. Levels 1 to 15 are the normal range, and level 16 sits above them so that a non-maskable line can always outrank the rest. Sources that are raised with a nonzero level are entered into a pending set. A source is held at most once in that set, and it stays there until an explicit clear strobe removes it.

A combinational compare tree runs across all eligible pending sources and finds the winner. The winner is the source with the highest level; when levels are equal, the lower source index wins. The block drives a registered request line toward the CPU. That line is high only when three conditions hold:

- a winner exists;
- the CPU block bit is clear;
- the CPU mask level is strictly below the winner's level.

The winner's exception vector code is always presented, together with a valid flag. Reading that code does not remove the source from the pending set.

Source indices are assigned as follows:

| Index | Source | Vector code | Default level |
|---|---|---|---|
| 0 to 14 | External lines | 0x200 + 0x20·i | 15 − i |
| 15 | Non-maskable line | 0x1C0 | 16 |
| 16 to 40 | Internal sources | 0x400 + 0x20·(i − 16) | 0 |

Index 16 is timer underflow 0 (code 0x400) and index 32 is the debug interface (code 0x600). The highest internal code is 0x700.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it is released, irq_req and vec_valid are 0 and vec_code is 0. Reset empties the pending set and loads the default levels: index i below 15 gets 15 − i, index 15 gets 16, and every other index gets 0.
- R2: A raise strobe is ignored for a source whose current level is 0, so that source never becomes pending.
- R3: A second raise of a source that is already pending adds no second entry. A single clear then leaves that source not pending.
- R4: Only pending sources with a nonzero level compete. The winner has the highest level, and on equal levels the lowest index wins.
- R5: irq_req is 1 exactly when a winner exists, block_bit is 0, and cpu_mask (zero-extended) is strictly less than the winner's level. It is re-evaluated on every change to the pending set, the levels, cpu_mask or block_bit.
- R6: A clear strobe removes its source from the pending set. Clearing a source that is not pending changes nothing. When raise and clear hit the same source in one cycle, the clear wins. Presenting the winner's vector does not remove it.
- R7: vec_code equals the winner's code from the source table above. When vec_valid is 0, vec_code is 0.
- R8: Asserting pri_wr_en loads pri_wr_val into source pri_wr_idx and leaves every other level unchanged. A pending source whose level is written to 0 stays pending but drops out of the competition.
- R9: irq_req, vec_valid and vec_code are registered. After a clock edge that samples a change on any input, they show the effect of that change, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise | input | 41 | Per-source raise strobes, bit i is source i |
| clear | input | 41 | Per-source clear strobes, bit i is source i |
| cpu_mask | input | 4 | CPU current interrupt mask level |
| block_bit | input | 1 | CPU global block bit, 1 holds the request line low |
| pri_wr_en | input | 1 | Level write enable |
| pri_wr_idx | input | 6 | Source index for the level write |
| pri_wr_val | input | 5 | Level value to write, 0 to 16 |
| irq_req | output | 1 | Interrupt request line to the CPU |
| vec_valid | output | 1 | A winner exists |
| vec_code | output | 12 | Vector code of the winner, 0 when none |

## Verification
Each of the 41 sources is raised on its own under the default levels. This separates the sources that are enabled by default from those that are off, and checks every table code individually.

A sweep covers all sixteen mask levels with the block bit both clear and set, first against a level-16 winner and then against a level-8 winner. This pins down the strict "less than" boundary and the effect of the block bit.

A custom level pattern with many equal-level groups is then loaded. All sources are raised at once and the winners are cleared one by one. This shows whether the ordering follows level first and index second, and whether level-0 sources stay out.

Directed sequences cover the remaining cases: a repeated raise, a clear of an idle source, raise and clear in the same cycle, a level written to 0 while pending, and the exact cycle in which outputs change.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SRC   = 41;
  localparam int PRI_W     = 5;
  localparam int MASK_W    = 4;
  localparam int VEC_W     = 12;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int EXT_LINES = 15;
  localparam int NMI_IDX   = 15;
  localparam int INT_BASE  = 16;

  typedef struct packed {
    logic             valid;
    logic [PRI_W-1:0] pri;
    logic [IDX_W-1:0] idx;
  } cand_t;

  // Exception vector code of a source index.
  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    int code;
    if (idx < EXT_LINES)     code = 32'h200 + 32'h20 * idx;
    else if (idx == NMI_IDX) code = 32'h1C0;
    else                     code = 32'h400 + 32'h20 * (idx - INT_BASE);
    return VEC_W'(code);
  endfunction

  // Level loaded at reset.
  function automatic logic [PRI_W-1:0] src_default_pri(input int idx);
    int p;
    if (idx < EXT_LINES)     p = EXT_LINES - idx;
    else if (idx == NMI_IDX) p = 16;
    else                     p = 0;
    return PRI_W'(p);
  endfunction

  // Combine two candidates; lo holds the lower indices and keeps ties.
  function automatic cand_t cand_pick(input cand_t lo, input cand_t hi);
    if (lo.valid && (!hi.valid || lo.pri >= hi.pri)) return lo;
    return hi;
  endfunction

  // Request-line decision.
  function automatic logic req_decide(input logic valid, input logic [PRI_W-1:0] pri,
                                      input logic [MASK_W-1:0] mask, input logic blk);
    return valid && !blk && (PRI_W'(mask) < pri);
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import prio_irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int PW = PRI_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [PW-1:0] wr_val,
  output logic [PW-1:0] pri_q [N],
  output logic [PW-1:0] pri_d [N]
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lvl
      logic hit;
      assign hit      = wr_en && (wr_idx == IW'(g));
      assign pri_d[g] = hit ? wr_val : pri_q[g];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pri_q[g] <= PW'(src_default_pri(g));
        else        pri_q[g] <= pri_d[g];
      end

      AST_PRI_HELD: assert property (@(posedge clk) disable iff (!rst_n) !$past(wr_en && (wr_idx == IW'(g))) |-> $stable(pri_q[g])); // R8
    end
  endgenerate
endmodule

// File: rtl/irq_pending_set.sv
module irq_pending_set
  import prio_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raise,
  input  logic [N-1:0] clear,
  input  logic [N-1:0] pri_nz,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_d
);
  logic [N-1:0] accepted;

  // A raise only counts for an enabled source; clear dominates.
  assign accepted = raise & pri_nz;
  assign pend_d   = (pend_q | accepted) & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n) ((pend_q & ~$past(pend_q) & ~$past(raise & pri_nz)) == '0)); // R2
  AST_CLEAR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n) ((pend_q & $past(clear)) == '0)); // R6
endmodule

// File: rtl/irq_winner_tree.sv
module irq_winner_tree
  import prio_irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int PW = PRI_W
) (
  input  logic [N-1:0]  pend,
  input  logic [PW-1:0] pri [N],
  output cand_t         win
);
  localparam int LVLS   = $clog2(N);
  localparam int LEAVES = 1 << LVLS;
  localparam int NODES  = 2 * LEAVES - 1;

  cand_t node [NODES];

  genvar g;
  generate
    for (g = 0; g < LEAVES; g++) begin : g_leaf
      if (g < N) begin : g_real
        assign node[LEAVES-1+g] = '{valid: pend[g] && (pri[g] != '0), pri: pri[g], idx: IDX_W'(g)};
      end else begin : g_pad
        assign node[LEAVES-1+g] = '0;
      end
    end
    for (g = 0; g < LEAVES - 1; g++) begin : g_node
      assign node[g] = cand_pick(node[2*g+1], node[2*g+2]);
    end
  endgenerate

  assign win = node[0];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int PW = PRI_W,
  parameter int MW = MASK_W,
  parameter int VW = VEC_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  raise,
  input  logic [N-1:0]  clear,
  input  logic [MW-1:0] cpu_mask,
  input  logic          block_bit,
  input  logic          pri_wr_en,
  input  logic [IW-1:0] pri_wr_idx,
  input  logic [PW-1:0] pri_wr_val,
  output logic          irq_req,
  output logic          vec_valid,
  output logic [VW-1:0] vec_code
);
  logic [PW-1:0] pri_q [N];
  logic [PW-1:0] pri_d [N];
  logic [N-1:0]  pri_nz;
  logic [N-1:0]  pend_q;
  logic [N-1:0]  pend_d;
  cand_t         win_next;
  logic          req_next;
  logic [VW-1:0] code_next;

  irq_prio_regs #(.N(N), .PW(PW), .IW(IW)) u_lvl (
    .clk(clk), .rst_n(rst_n), .wr_en(pri_wr_en), .wr_idx(pri_wr_idx),
    .wr_val(pri_wr_val), .pri_q(pri_q), .pri_d(pri_d)
  );

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_nz
      assign pri_nz[g] = (pri_q[g] != '0);
    end
  endgenerate

  irq_pending_set #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n), .raise(raise), .clear(clear),
    .pri_nz(pri_nz), .pend_q(pend_q), .pend_d(pend_d)
  );

  // Compare on next state so outputs follow inputs by one edge.
  irq_winner_tree #(.N(N), .PW(PW)) u_tree (
    .pend(pend_d), .pri(pri_d), .win(win_next)
  );

  assign req_next  = req_decide(win_next.valid, win_next.pri, cpu_mask, block_bit);
  assign code_next = win_next.valid ? VW'(src_vector(int'(win_next.idx))) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      vec_valid <= 1'b0;
      vec_code  <= '0;
    end else begin
      irq_req   <= req_next;
      vec_valid <= win_next.valid;
      vec_code  <= code_next;
    end
  end

  AST_REQ_NEEDS_WIN: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> vec_valid); // R5
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> !$past(block_bit)); // R5
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) vec_valid |-> (vec_code[4:0] == 5'd0 && vec_code != '0)); // R7
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n) !vec_valid |-> (vec_code == '0 && !irq_req)); // R7
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int N = 41;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] raise = '0;
  logic [N-1:0] clear = '0;
  logic [3:0]  cpu_mask = 4'd0;
  logic        block_bit = 1'b0;
  logic        pri_wr_en = 1'b0;
  logic [5:0]  pri_wr_idx = 6'd0;
  logic [4:0]  pri_wr_val = 5'd0;
  logic        irq_req;
  logic        vec_valid;
  logic [11:0] vec_code;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .raise(raise), .clear(clear),
    .cpu_mask(cpu_mask), .block_bit(block_bit), .pri_wr_en(pri_wr_en),
    .pri_wr_idx(pri_wr_idx), .pri_wr_val(pri_wr_val),
    .irq_req(irq_req), .vec_valid(vec_valid), .vec_code(vec_code)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int m_pri [N];
  bit m_pend [N];

  function automatic int exp_vec(input int i);
    case (1'b1)
      (i == 15): return 448;
      (i < 15):  return 512 + i * 32;
      default:   return 1024 + (i - 16) * 32;
    endcase
  endfunction

  function automatic int exp_defpri(input int i);
    if (i == 15) return 16;
    if (i < 15)  return 15 - i;
    return 0;
  endfunction

  task automatic exp_win(output bit v, output int w);
    v = 0; w = 0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_pri[i] > 0 && (!v || m_pri[i] > m_pri[w])) begin
        v = 1; w = i;
      end
  endtask

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check(input string tag);
    bit v; int w; int er;
    exp_win(v, w);
    er = (v && !block_bit && int'(cpu_mask) < m_pri[w]) ? 1 : 0;
    cmp({tag, " valid"}, int'(vec_valid), v ? 1 : 0);
    cmp({tag, " code"}, int'(vec_code), v ? exp_vec(w) : 0);
    cmp({tag, " req"}, int'(irq_req), er);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; raise = '0; clear = '0; pri_wr_en = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_pri[i] = exp_defpri(i); end
  endtask

  task automatic do_raise(input int i);
    raise[i] = 1'b1;
    if (m_pri[i] > 0) m_pend[i] = 1;
    cyc();
    raise = '0;
  endtask

  task automatic do_clear(input int i);
    clear[i] = 1'b1;
    m_pend[i] = 0;
    cyc();
    clear = '0;
  endtask

  task automatic do_write(input int i, input int v);
    pri_wr_en = 1'b1; pri_wr_idx = 6'(i); pri_wr_val = 5'(v);
    m_pri[i] = v;
    cyc();
    pri_wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit v; int w;
    cyc();
    // R1: outputs idle during reset
    cmp("R1 reset req", int'(irq_req), 0);
    cmp("R1 reset valid", int'(vec_valid), 0);
    do_reset();
    cyc();
    check("R1 after release");

    // R1 R7 R2: each source alone under default levels
    for (int i = 0; i < N; i++) begin
      do_raise(i);
      check($sformatf("R7 src %0d", i));
      do_clear(i);
      check($sformatf("R6 clr %0d", i));
    end

    // R5: mask and block sweep against level 16 and level 8
    do_raise(15);
    for (int b = 0; b < 2; b++)
      for (int m = 0; m < 16; m++) begin
        cpu_mask = 4'(m); block_bit = 1'(b);
        cyc();
        check($sformatf("R5 nmi m%0d b%0d", m, b));
      end
    do_clear(15);
    do_raise(7);
    for (int b = 0; b < 2; b++)
      for (int m = 0; m < 16; m++) begin
        cpu_mask = 4'(m); block_bit = 1'(b);
        cyc();
        check($sformatf("R5 irq7 m%0d b%0d", m, b));
      end
    cpu_mask = 4'd0; block_bit = 1'b0;
    do_clear(7);
    check("R5 empty");

    // R9: change not visible before the edge
    raise[3] = 1'b1; m_pend[3] = 1;
    #1;
    cmp("R9 before edge", int'(vec_valid), 0);
    cyc();
    raise = '0;
    check("R9 after edge");

    // R3: repeated raise, single clear
    do_raise(3);
    check("R3 repeat");
    do_clear(3);
    check("R3 one clear empties");

    // R6: clear idle source, simultaneous raise and clear, no removal on view
    do_raise(5);
    do_clear(9);
    check("R6 idle clear");
    cyc(); cyc();
    check("R6 held while presented");
    raise[4] = 1'b1; clear[4] = 1'b1;
    cyc();
    raise = '0; clear = '0;
    check("R6 clear wins");
    do_clear(5);

    // R8 R4: level writes, tie with lower index, write to 0 while pending
    do_write(20, 16);
    do_raise(20);
    do_raise(15);
    check("R4 tie lower index");
    do_clear(15);
    check("R8 written level wins");
    do_write(20, 0);
    check("R8 zeroed pending excluded");
    do_write(20, 3);
    check("R8 restored still pending");
    do_clear(20);

    // R4: full ordering sweep with many equal levels
    do_reset();
    for (int i = 0; i < N; i++) do_write(i, (i * 7 + 3) % 17);
    check("R4 no pending");
    raise = '1;
    for (int i = 0; i < N; i++) if (m_pri[i] > 0) m_pend[i] = 1;
    cyc();
    raise = '0;
    for (int k = 0; k < N + 1; k++) begin
      check($sformatf("R4 order step %0d", k));
      exp_win(v, w);
      if (!v) break;
      do_clear(w);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule